// File: doc/BRIEF.md
# Miss-Address Correlation Predictor

This block learns which cache-miss line addresses tend to follow one another and, when a miss address comes around again, proposes the addresses that followed it in the past. Upstream logic filters out sequential misses, so the block only sees the irregular ones. Each miss drives the block in two ways in the same cycle. It is written into the table as a successor of the misses that came before it, and it is looked up to produce predictions.

The table is set associative, with two ways per set and `SETS` sets. A line address is split into a set index, taken from its low `log2(SETS)` bits, and a tag of `TAG_W` bits taken from the bits directly above the index. Bits above the tag take no part in matching. Every entry holds two first-level successors (misses that came right after it) and two second-level successors (misses that came two steps later). Each successor is stored as a signed `OFF_W`-bit offset from the entry's own address rather than as a full address. All four candidate addresses are presented together, a fixed `LAT` cycles after the miss.

Top module: `corr_predictor`

## Requirements
- R1: While `rst_n` is low and after it is released, the table is empty, the miss history is cleared, and `pred_vld` and `pred_addr` read zero. Addresses learned before a reset never produce predictions after it.
- R2: The predictions for a miss presented in cycle c appear in cycle c+`LAT` and last one cycle only. In every other cycle `pred_vld` is zero.
- R3: A miss whose set holds no valid way with a matching tag produces `pred_vld` = 0. This includes the first miss after reset.
- R4: A miss is recorded as the newest first-level successor of the previous miss. The earlier newest successor moves to the older first-level slot, and the older one is discarded. Slot 0 of the outputs (`pred_vld[0]`, `pred_addr[ADDR_W-1:0]`) is the newest first-level successor, and slot 1 is the older one.
- R5: A miss is recorded in the same way as the newest second-level successor of the miss before the previous one. Slot 2 carries the newest second-level successor and slot 3 the older one.
- R6: A successor is stored as the signed two's-complement difference (successor − owner) in `OFF_W` bits. A predicted address is the miss address plus the sign-extended offset, modulo 2^`ADDR_W`. Offsets of zero and negative offsets are legal.
- R7: If the difference does not fit in `OFF_W` signed bits, that single update is dropped. No entry is allocated or changed.
- R8: Recording into an owner that has no entry allocates the least-recently-written way of its set. The new entry holds only the new successor. Every write, including one that hits, makes its way the most recently written.
- R9: A lookup returns the table contents from before the recordings made in the same cycle. When the first-level and second-level recordings of one miss land in the same set, the first-level one is applied first.
- R10: Cycles with `miss_valid` low change neither the table nor the miss history, whatever `miss_addr` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A non-sequential miss is presented this cycle |
| miss_addr | input | ADDR_W | Line address of the miss |
| pred_vld | output | 4 | Per-slot prediction valid (slots 0,1 first level; 2,3 second level) |
| pred_addr | output | 4*ADDR_W | Predicted line addresses, slot k at bits [k*ADDR_W +: ADDR_W], zero when invalid |

## Verification
Two things can fall on the same set in the same cycle: the lookup of the current miss, and the writes that record it as a successor of earlier misses. The bench sets this up in two ways. In the first, three addresses share one set, so a single miss both reads that set and evicts and reallocates ways in it. In the second, back-to-back misses make one entry receive a first-level and a second-level successor in the same cycle. In both cases the outcome is judged from the prediction slots, which must show the table as it stood before that cycle's recording and the same-cycle updates applied in first-level-then-second-level order.

// File: rtl/corr_predictor.sv
module corr_predictor #(
  parameter int ADDR_W = 26,
  parameter int SETS   = 64,
  parameter int TAG_W  = 11,
  parameter int OFF_W  = 17,
  parameter int LAT    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  miss_valid,
  input  logic [ADDR_W-1:0]     miss_addr,
  output logic [3:0]            pred_vld,
  output logic [4*ADDR_W-1:0]   pred_addr
);
  localparam int IDX_W = $clog2(SETS);

  typedef struct packed {
    logic                   v;
    logic [TAG_W-1:0]       tag;
    logic [1:0]             v1;
    logic [1:0][OFF_W-1:0]  o1;
    logic [1:0]             v2;
    logic [1:0][OFF_W-1:0]  o2;
  } ent_t;

  typedef struct packed {
    logic       lru;
    ent_t [1:0] w;
  } set_t;

  set_t tbl [SETS];

  logic [ADDR_W-1:0] prev1, prev2;
  logic              p1v, p2v;

  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[IDX_W+TAG_W-1:IDX_W];
  endfunction

  function automatic logic fits(logic [ADDR_W:0] d);
    return (&d[ADDR_W:OFF_W-1]) | ~(|d[ADDR_W:OFF_W-1]);
  endfunction

  function automatic logic [ADDR_W-1:0] sx(logic [OFF_W-1:0] o);
    return {{(ADDR_W-OFF_W){o[OFF_W-1]}}, o};
  endfunction

  function automatic set_t record(set_t s, logic [TAG_W-1:0] tg,
                                  logic [OFF_W-1:0] off, logic lvl);
    set_t r;
    logic w, hit;
    r = s;
    w = s.lru;
    hit = 1'b0;
    for (int i = 0; i < 2; i++)
      if (s.w[i].v && s.w[i].tag == tg) begin
        w = 1'(i);
        hit = 1'b1;
      end
    if (!hit) begin
      r.w[w]     = '0;
      r.w[w].v   = 1'b1;
      r.w[w].tag = tg;
    end
    if (lvl) begin
      r.w[w].o2 = {r.w[w].o2[0], off};
      r.w[w].v2 = {r.w[w].v2[0], 1'b1};
    end else begin
      r.w[w].o1 = {r.w[w].o1[0], off};
      r.w[w].v1 = {r.w[w].v1[0], 1'b1};
    end
    r.lru = ~w;
    return r;
  endfunction

  // lookup against the table as it stands before this cycle's writes
  ent_t                le;
  logic [3:0]          s0_vld;
  logic [4*ADDR_W-1:0] s0_addr;

  always_comb begin
    set_t ls;
    logic [OFF_W-1:0] o;
    ls = tbl[idx_of(miss_addr)];
    le = '0;
    for (int i = 0; i < 2; i++)
      if (ls.w[i].v && ls.w[i].tag == tag_of(miss_addr)) le = ls.w[i];
    s0_vld = miss_valid ? {le.v2, le.v1} : 4'b0;
    for (int k = 0; k < 4; k++) begin
      o = (k < 2) ? le.o1[k%2] : le.o2[k%2];
      s0_addr[k*ADDR_W +: ADDR_W] = s0_vld[k] ? miss_addr + sx(o) : '0;
    end
  end

  // successor recording: first level into prev1, then second level into prev2
  logic [ADDR_W:0] d1, d2;
  logic            do1, do2;
  set_t            r1, r2;

  assign d1  = {1'b0, miss_addr} - {1'b0, prev1};
  assign d2  = {1'b0, miss_addr} - {1'b0, prev2};
  assign do1 = miss_valid && p1v && fits(d1);
  assign do2 = miss_valid && p2v && fits(d2);
  assign r1  = record(tbl[idx_of(prev1)], tag_of(prev1), d1[OFF_W-1:0], 1'b0);
  assign r2  = record((do1 && idx_of(prev1) == idx_of(prev2)) ? r1 : tbl[idx_of(prev2)],
                      tag_of(prev2), d2[OFF_W-1:0], 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tbl[s] <= '0;
      prev1 <= '0;
      prev2 <= '0;
      p1v   <= 1'b0;
      p2v   <= 1'b0;
    end else if (miss_valid) begin
      if (do1) tbl[idx_of(prev1)] <= r1;
      if (do2) tbl[idx_of(prev2)] <= r2;
      prev2 <= prev1;
      p2v   <= p1v;
      prev1 <= miss_addr;
      p1v   <= 1'b1;
    end
  end

  // fixed-latency delivery
  logic [3:0]          pv [LAT];
  logic [4*ADDR_W-1:0] pa [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        pv[i] <= '0;
        pa[i] <= '0;
      end
    end else begin
      pv[0] <= s0_vld;
      pa[0] <= s0_addr;
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pa[i] <= pa[i-1];
      end
    end
  end

  assign pred_vld  = pv[LAT-1];
  assign pred_addr = pa[LAT-1];
endmodule

// File: rtl/corr_predictor_chk.sv
module corr_predictor_chk #(
  parameter int LAT = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       miss_valid,
  input logic [3:0] pred_vld
);
  logic [LAT-1:0] hist, fst;
  logic           seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      fst  <= '0;
      seen <= 1'b0;
    end else begin
      hist <= LAT'({hist, miss_valid});
      fst  <= LAT'({fst, miss_valid & ~seen});
      if (miss_valid) seen <= 1'b1;
    end
  end

  // R2
  lat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_vld != 4'b0) |-> hist[LAT-1]);

  // R3
  first_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fst[LAT-1] |-> (pred_vld == 4'b0));

  // R4
  l1_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld[1] |-> pred_vld[0]);

  // R5
  l2_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld[3] |-> pred_vld[2]);
endmodule

bind corr_predictor corr_predictor_chk #(.LAT(LAT)) i_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .pred_vld(pred_vld)
);

// File: tb/test_corr_predictor.sv
module test_corr_predictor;
  localparam int AW  = 26;
  localparam int LAT = 8;
  localparam int NV  = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic [3:0]    pred_vld;
  logic [4*AW-1:0] pred_addr;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  corr_predictor i_corr_predictor (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .pred_vld(pred_vld), .pred_addr(pred_addr)
  );

  typedef struct packed {
    logic [AW-1:0] a;
    logic [3:0]    v;
    logic [AW-1:0] p0, p1, p2, p3;
  } vec_t;

  // A=1000 (set 0), B=1041 (set 1), C=1083 (set 3), D=30005 (set 5), X/Y/Z=49/89/c9 (set 9)
  localparam vec_t VEC [NV] = '{
    '{26'h1000,  4'b0000, 26'h0,     26'h0,    26'h0,     26'h0},    // R3 first miss
    '{26'h1041,  4'b0000, 26'h0,     26'h0,    26'h0,     26'h0},    // R3
    '{26'h1083,  4'b0000, 26'h0,     26'h0,    26'h0,     26'h0},    // R3
    '{26'h1000,  4'b0101, 26'h1041,  26'h0,    26'h1083,  26'h0},    // R4 R5
    '{26'h1041,  4'b0101, 26'h1083,  26'h0,    26'h1000,  26'h0},    // R6 negative offset
    '{26'h1083,  4'b0101, 26'h1000,  26'h0,    26'h1041,  26'h0},    // R6
    '{26'h1000,  4'b1111, 26'h1041,  26'h1041, 26'h1083,  26'h1083}, // R4 R5 shift
    '{26'h30005, 4'b0000, 26'h0,     26'h0,    26'h0,     26'h0},    // R3
    '{26'h1000,  4'b1111, 26'h1041,  26'h1041, 26'h1083,  26'h1083}, // R7 dropped updates
    '{26'h30005, 4'b0000, 26'h0,     26'h0,    26'h0,     26'h0},    // R7 no allocation
    '{26'h30005, 4'b0100, 26'h0,     26'h0,    26'h30005, 26'h0},    // R6 zero offset
    '{26'h30005, 4'b0101, 26'h30005, 26'h0,    26'h30005, 26'h0},    // R6
    '{26'h49,    4'b0000, 26'h0,     26'h0,    26'h0,     26'h0},    // R3
    '{26'h89,    4'b0000, 26'h0,     26'h0,    26'h0,     26'h0},    // R8 alloc
    '{26'hc9,    4'b0000, 26'h0,     26'h0,    26'h0,     26'h0},    // R8 R9 same set
    '{26'h49,    4'b0101, 26'h89,    26'h0,    26'hc9,    26'h0},    // R9 lookup before write
    '{26'h89,    4'b0100, 26'h0,     26'h0,    26'h49,    26'h0},    // R8 eviction
    '{26'h49,    4'b0001, 26'h89,    26'h0,    26'h0,     26'h0},    // R8 realloc
    '{26'hc9,    4'b0000, 26'h0,     26'h0,    26'h0,     26'h0}     // R8 evicted
  };

  task automatic check_pred(input string req, input logic [3:0] ev,
                            input logic [AW-1:0] e0, e1, e2, e3);
    logic [4*AW-1:0] ea;
    ea = {e3, e2, e1, e0};
    checks++;
    if (pred_vld !== ev || pred_addr !== ea) begin
      errors++;
      $display("FAIL %s: vld=%b addr=%h expected vld=%b addr=%h",
               req, pred_vld, pred_addr, ev, ea);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    miss_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_600_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    check_pred("R1 reset", 4'b0, '0, '0, '0, '0);

    for (int n = 0; n < NV; n++) begin
      int quiet_bad;
      quiet_bad = 0;
      @(negedge clk);
      miss_valid = 1'b1;
      miss_addr  = VEC[n].a;
      for (int c = 1; c <= LAT; c++) begin
        @(negedge clk);
        miss_valid = 1'b0;
        miss_addr  = ~VEC[n].a; // R10: ignored while miss_valid is low
        if (c < LAT && pred_vld !== 4'b0) quiet_bad++;
        if (c == LAT)
          check_pred($sformatf("R3-R9 vector %0d", n), VEC[n].v,
                     VEC[n].p0, VEC[n].p1, VEC[n].p2, VEC[n].p3);
      end
      // R2: nothing before the fixed latency
      checks++;
      if (quiet_bad != 0) begin
        errors++;
        $display("FAIL R2 vector %0d: %0d early cycles with predictions, expected 0", n, quiet_bad);
      end
    end

    // R1: learned contents gone after reset
    do_reset();
    check_pred("R1 after reset", 4'b0, '0, '0, '0, '0);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = 26'h1000;
    for (int c = 1; c <= LAT; c++) begin
      @(negedge clk);
      miss_valid = 1'b0;
    end
    check_pred("R1 forgotten", 4'b0, '0, '0, '0, '0);

    // back-to-back A,B,A: one entry gets first- and second-level writes together (R9, R2)
    for (int c = 0; c <= LAT + 3; c++) begin
      @(negedge clk);
      if (c == LAT)     check_pred("R2 b2b slot", 4'b0, '0, '0, '0, '0);
      if (c == LAT + 1) check_pred("R2 b2b slot", 4'b0, '0, '0, '0, '0);
      if (c == LAT + 2) check_pred("R9 b2b", 4'b0111, 26'h1041, 26'h1000, 26'h1041, '0);
      if (c == LAT + 3) check_pred("R2 one cycle", 4'b0, '0, '0, '0, '0);
      miss_valid = (c < 3);
      miss_addr  = (c == 1) ? 26'h1041 : 26'h1000;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule